// File: doc/BRIEF.md
# Masked Byte Register File with Side Effects

This block is a byte-wide control and status register file that sits behind a simple single-cycle bus. The bus has an 8-bit address, write data with a write enable, and a read strobe. Read data appears one cycle after the strobe. The file holds several kinds of register:

- identification bytes, including a 32-bit program identifier captured after reset;
- read-only snapshots of external live counters;
- read/write reload values fed straight to those counters;
- watchdog timeout and pulse-length settings, plus a watchdog event counter;
- a window onto an external state machine's current state;
- a virtual input byte and a virtual output byte;
- a serial configuration bit that enables address auto-increment.

Three accesses have side effects. Reading the watchdog event counter clears it. Writing the state register sends a one-cycle load pulse, with a 3-bit state, to the external state machine. A global mask register gates every later access: bits outside the mask read as zero and keep their old value on a write. The mask register itself is exempt from the mask, so software can always reopen it.

The counters, the watchdog and the state machine live outside this block and connect through ports. The parameter `NCNT` sets the number of counters. It must be between 7 and 16, so that the counter-6 reload register at 0x26 exists.

Top module: `ctl_regfile`

## Requirements
- R1: After reset the counter reload bytes equal `CNT_INIT` (0x80), the watchdog timeout is 0x10, the pulse length is 0x04, the virtual input byte is 0x00, auto-increment is 0, the mask is 0xFF, read data is 0x00, and no load pulse is active.
- R2: Addresses 0x00 to 0x07 are identification bytes and ignore writes: 0x00 returns 0x12, 0x01 returns 0x02, 0x02 returns 0x00 and 0x03 returns the revision 0x01. Addresses 0x04 to 0x07 return `prog_id_i` as captured on the first clock after reset, most significant byte at 0x04.
- R3: A read strobe in cycle N puts the value of the addressed register on `bus_rdata_o` in cycle N+1, as it stood before any write in cycle N. Without a strobe, `bus_rdata_o` holds its last value.
- R4: Address 0x10+i returns byte i of `cnt_live_i` (bits 8i+7:8i), sampled in the cycle of the strobe. Writes there are ignored.
- R5: Address 0x20+i is the read/write reload byte for counter i, driven on `cnt_reload_o` bits 8i+7:8i from the cycle after the write. Counter 6 is therefore at 0x26.
- R6: Address 0x32 counts the cycles in which `wd_event_i` is high and saturates at 0xFF. A read returns the count and clears it; an event in the read cycle leaves the count at 1.
- R7: Reading 0x38 returns `fsm_state_i` in bits 2:0 with zeros above. A write to 0x38 raises `fsm_load_o` for exactly the next cycle, with `fsm_load_val_o` equal to the masked write data merged with the current state in bits 2:0.
- R8: The mask at 0xF8 is written and read in full, unmasked. For every other address, read data is ANDed with the mask, and on a write only bits set in the mask take the new value.
- R9: Address 0xE0 is the read/write virtual input byte, driven on `vin_o`. Address 0xE1 returns `vout_i` and ignores writes.
- R10: Bit 0 of address 0xF0 is the auto-increment enable, driven on `autoinc_o`. The other bits of 0xF0 read as 0.
- R11: Reads from unmapped addresses return 0x00. Writes to unmapped or read-only addresses change no register.
- R12: Address 0x30 holds the watchdog timeout and 0x31 the pulse length. Both are read/write and drive `wd_timeout_o` and `wd_pulse_o` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write enable |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Registered read data |
| prog_id_i | input | 32 | Program identifier, captured once after reset |
| cnt_live_i | input | NCNT*8 | Live counter values |
| cnt_reload_o | output | NCNT*8 | Counter reload values |
| wd_event_i | input | 1 | Watchdog fired this cycle |
| wd_timeout_o | output | 8 | Watchdog timeout setting |
| wd_pulse_o | output | 8 | Watchdog pulse-length setting |
| fsm_state_i | input | 3 | External state machine's current state |
| fsm_load_o | output | 1 | One-cycle force-state pulse |
| fsm_load_val_o | output | 3 | State to force |
| vin_o | output | 8 | Virtual input byte |
| vout_i | input | 8 | Virtual output byte |
| autoinc_o | output | 1 | Address auto-increment enable |

## Verification
A wrong stored byte shows at the ports within a cycle through the dedicated outputs: reload values, watchdog settings, virtual input and auto-increment. It also shows on `bus_rdata_o` one cycle after any read of that address. A wrong mask or event count shows only when a later access uses it, so the bench reads back after every masked write and after each burst of events. A reference model compares every output on every clock, so the first divergent cycle is reported, not just the end result.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

   localparam logic [7:0] A_SNAP_BASE = 8'h10;
   localparam logic [7:0] A_DATA_BASE = 8'h20;
   localparam logic [7:0] A_WD_TMO    = 8'h30;
   localparam logic [7:0] A_WD_PULSE  = 8'h31;
   localparam logic [7:0] A_WD_EVT    = 8'h32;
   localparam logic [7:0] A_FSM       = 8'h38;
   localparam logic [7:0] A_VIN       = 8'hE0;
   localparam logic [7:0] A_VOUT      = 8'hE1;
   localparam logic [7:0] A_SCFG      = 8'hF0;
   localparam logic [7:0] A_MASK      = 8'hF8;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_ID, SEL_SNAP, SEL_DATA, SEL_WD_TMO, SEL_WD_PULSE,
      SEL_WD_EVT, SEL_FSM, SEL_VIN, SEL_VOUT, SEL_SCFG, SEL_MASK
   } sel_e;

   typedef struct packed {
      sel_e       sel;
      logic [3:0] idx;
   } dec_t;

endpackage

// File: rtl/rf_decode.sv
module rf_decode
   import ctl_regfile_pkg::*;
#(
   parameter int unsigned NCNT = 8
) (
   input  logic [7:0] addr_i,
   output dec_t       dec_o
);

   localparam int unsigned SNAP_END = int'(A_SNAP_BASE) + NCNT;
   localparam int unsigned DATA_END = int'(A_DATA_BASE) + NCNT;

   always_comb begin
      dec_o.sel = SEL_NONE;
      dec_o.idx = '0;
      if (addr_i < 8'h08) begin
         dec_o.sel = SEL_ID;
         dec_o.idx = {1'b0, addr_i[2:0]};
      end else if (addr_i >= A_SNAP_BASE && int'(addr_i) < SNAP_END) begin
         dec_o.sel = SEL_SNAP;
         dec_o.idx = addr_i[3:0];
      end else if (addr_i >= A_DATA_BASE && int'(addr_i) < DATA_END) begin
         dec_o.sel = SEL_DATA;
         dec_o.idx = addr_i[3:0];
      end else begin
         case (addr_i)
            A_WD_TMO:   dec_o.sel = SEL_WD_TMO;
            A_WD_PULSE: dec_o.sel = SEL_WD_PULSE;
            A_WD_EVT:   dec_o.sel = SEL_WD_EVT;
            A_FSM:      dec_o.sel = SEL_FSM;
            A_VIN:      dec_o.sel = SEL_VIN;
            A_VOUT:     dec_o.sel = SEL_VOUT;
            A_SCFG:     dec_o.sel = SEL_SCFG;
            A_MASK:     dec_o.sel = SEL_MASK;
            default:    dec_o.sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/rf_rw_byte.sv
module rf_rw_byte #(
   parameter int unsigned    DW  = 8,
   parameter logic [DW-1:0]  RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] mask_i,
   output logic [DW-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RST;
      else if (we_i) q_o <= (wdata_i & mask_i) | (q_o & ~mask_i);
   end

   // Bits outside the mask never move, whatever is written.
   assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((q_o ^ $past(q_o)) & ~$past(mask_i)) == '0);

endmodule

// File: rtl/rf_evt_count.sv
module rf_evt_count #(
   parameter int unsigned DW       = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_i,
   input  logic          clr_i,
   output logic [DW-1:0] q_o
);

   localparam logic [DW-1:0] TOP = '1;
   logic [DW-1:0] inc;

   generate
      if (SATURATE) begin : g_sat
         assign inc = (q_o == TOP) ? q_o : q_o + 1'b1;
      end else begin : g_wrap
         assign inc = q_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (clr_i)  q_o <= evt_i ? DW'(1) : '0;
      else if (evt_i)  q_o <= inc;
   end

   assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> (q_o == '0));
   assert_event_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && evt_i && q_o != TOP) |=> (q_o == $past(q_o) + 1'b1));

   generate
      if (SATURATE) begin : g_sat_chk
         assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && q_o == TOP) |=> (q_o == TOP));
      end
   endgenerate

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
   import ctl_regfile_pkg::*;
#(
   parameter int unsigned   DW            = 8,
   parameter int unsigned   NCNT          = 8,
   parameter logic [7:0]    DEV_CODE0     = 8'h12,
   parameter logic [7:0]    DEV_CODE1     = 8'h02,
   parameter logic [7:0]    DEV_REV       = 8'h01,
   parameter logic [7:0]    CNT_INIT      = 8'h80,
   parameter logic [7:0]    WD_TMO_INIT   = 8'h10,
   parameter logic [7:0]    WD_PULSE_INIT = 8'h04,
   parameter bit            WD_SATURATE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         bus_addr_i,
   input  logic [7:0]         bus_wdata_i,
   input  logic               bus_we_i,
   input  logic               bus_re_i,
   output logic [7:0]         bus_rdata_o,
   input  logic [31:0]        prog_id_i,
   input  logic [NCNT*8-1:0]  cnt_live_i,
   output logic [NCNT*8-1:0]  cnt_reload_o,
   input  logic               wd_event_i,
   output logic [7:0]         wd_timeout_o,
   output logic [7:0]         wd_pulse_o,
   input  logic [2:0]         fsm_state_i,
   output logic               fsm_load_o,
   output logic [2:0]         fsm_load_val_o,
   output logic [7:0]         vin_o,
   input  logic [7:0]         vout_i,
   output logic               autoinc_o
);

   localparam int unsigned ID_BYTES = 4;
   localparam int unsigned SW       = 3;
   localparam logic [DW-1:0] ONES   = '1;

   generate
      if (DW != 8) begin : g_bad_dw
         initial $fatal(1, "ctl_regfile: DW must be 8");
      end
      if (NCNT < 7 || NCNT > 16) begin : g_bad_ncnt
         initial $fatal(1, "ctl_regfile: NCNT must be within 7..16");
      end
   endgenerate

   dec_t          dec;
   logic [DW-1:0] mask_q;
   logic [31:0]   pid_q;
   logic          pid_done_q;
   logic [DW-1:0] data_q [NCNT];
   logic [DW-1:0] scfg_q;
   logic [DW-1:0] wd_evt_q;
   logic [DW-1:0] rd_val;

   rf_decode #(.NCNT(NCNT)) u_dec (.addr_i(bus_addr_i), .dec_o(dec));

   // Mask register: exempt from itself so it can always be reopened.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mask_q <= ONES;
      else if (bus_we_i && dec.sel == SEL_MASK) mask_q <= bus_wdata_i;
   end

   // Program identifier captured once on the first clock after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pid_q      <= '0;
         pid_done_q <= 1'b0;
      end else if (!pid_done_q) begin
         pid_q      <= prog_id_i;
         pid_done_q <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_cnt
         rf_rw_byte #(.DW(DW), .RST(CNT_INIT)) u_data (
            .clk(clk), .rst_n(rst_n),
            .we_i(bus_we_i && dec.sel == SEL_DATA && int'(dec.idx) == i),
            .wdata_i(bus_wdata_i), .mask_i(mask_q), .q_o(data_q[i]));
         assign cnt_reload_o[i*8 +: 8] = data_q[i];
      end
   endgenerate

   rf_rw_byte #(.DW(DW), .RST(WD_TMO_INIT)) u_wd_tmo (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we_i && dec.sel == SEL_WD_TMO),
      .wdata_i(bus_wdata_i), .mask_i(mask_q), .q_o(wd_timeout_o));

   rf_rw_byte #(.DW(DW), .RST(WD_PULSE_INIT)) u_wd_pulse (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we_i && dec.sel == SEL_WD_PULSE),
      .wdata_i(bus_wdata_i), .mask_i(mask_q), .q_o(wd_pulse_o));

   rf_rw_byte #(.DW(DW), .RST('0)) u_vin (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we_i && dec.sel == SEL_VIN),
      .wdata_i(bus_wdata_i), .mask_i(mask_q), .q_o(vin_o));

   rf_rw_byte #(.DW(DW), .RST('0)) u_scfg (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we_i && dec.sel == SEL_SCFG),
      .wdata_i(bus_wdata_i), .mask_i(mask_q), .q_o(scfg_q));
   assign autoinc_o = scfg_q[0];

   rf_evt_count #(.DW(DW), .SATURATE(WD_SATURATE)) u_wd_evt (
      .clk(clk), .rst_n(rst_n), .evt_i(wd_event_i),
      .clr_i(bus_re_i && dec.sel == SEL_WD_EVT), .q_o(wd_evt_q));

   // Force-state pulse, merged with the live state outside the mask.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_load_o     <= 1'b0;
         fsm_load_val_o <= '0;
      end else begin
         fsm_load_o <= bus_we_i && dec.sel == SEL_FSM;
         if (bus_we_i && dec.sel == SEL_FSM)
            fsm_load_val_o <= (bus_wdata_i[SW-1:0] & mask_q[SW-1:0]) |
                              (fsm_state_i & ~mask_q[SW-1:0]);
      end
   end

   function automatic logic [7:0] id_byte(input logic [3:0] k, input logic [31:0] pid);
      case (k)
         4'd0:    id_byte = DEV_CODE0;
         4'd1:    id_byte = DEV_CODE1;
         4'd2:    id_byte = 8'h00;
         4'd3:    id_byte = DEV_REV;
         default: id_byte = pid[(ID_BYTES - 1 - (int'(k) - 4)) * 8 +: 8];
      endcase
   endfunction

   always_comb begin
      rd_val = '0;
      case (dec.sel)
         SEL_ID:       rd_val = id_byte(dec.idx, pid_q);
         SEL_SNAP:     rd_val = cnt_live_i[int'(dec.idx) * 8 +: 8];
         SEL_DATA:     rd_val = data_q[int'(dec.idx) % NCNT];
         SEL_WD_TMO:   rd_val = wd_timeout_o;
         SEL_WD_PULSE: rd_val = wd_pulse_o;
         SEL_WD_EVT:   rd_val = wd_evt_q;
         SEL_FSM:      rd_val = {{(DW-SW){1'b0}}, fsm_state_i};
         SEL_VIN:      rd_val = vin_o;
         SEL_VOUT:     rd_val = vout_i;
         SEL_SCFG:     rd_val = {{(DW-1){1'b0}}, scfg_q[0]};
         SEL_MASK:     rd_val = mask_q;
         default:      rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bus_rdata_o <= '0;
      else if (bus_re_i) bus_rdata_o <= (dec.sel == SEL_MASK) ? rd_val : (rd_val & mask_q);
   end

   assert_load_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_load_o |-> ($past(bus_we_i) && $past(bus_addr_i) == A_FSM));
   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_re_i) && $past(dec.sel) == SEL_NONE) |-> (bus_rdata_o == '0));
   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_re_i) |-> $stable(bus_rdata_o));
   assert_masked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_re_i) && $past(dec.sel) != SEL_MASK) |-> ((bus_rdata_o & ~$past(mask_q)) == '0));

endmodule

// File: tb/sim_ctl_regfile.sv
module sim_ctl_regfile;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic we = 1'b0, re = 1'b0;
   logic [7:0] rdata;
   logic [31:0] prog_id = 32'hA5C3_1E77;
   logic [NC*8-1:0] live, reload;
   logic evt = 1'b0;
   logic [7:0] tmo, pulse, vin, vout = 8'hC6;
   logic [2:0] fsm_q = 3'd5;
   logic load;
   logic [2:0] load_val;
   logic autoinc;
   logic [7:0] live_base = 8'd0;

   int compared = 0, mismatched = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) live_base <= live_base + 8'd3;
   always_comb for (int i = 0; i < NC; i++) live[i*8 +: 8] = live_base + 8'(i*16);

   always @(negedge clk) if (load) fsm_q <= load_val;

   ctl_regfile u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata), .prog_id_i(prog_id),
      .cnt_live_i(live), .cnt_reload_o(reload), .wd_event_i(evt),
      .wd_timeout_o(tmo), .wd_pulse_o(pulse), .fsm_state_i(fsm_q),
      .fsm_load_o(load), .fsm_load_val_o(load_val), .vin_o(vin),
      .vout_i(vout), .autoinc_o(autoinc));

   // ---------------- reference model ----------------
   logic [7:0] m_data [NC];
   logic [7:0] m_tmo, m_pulse, m_vin, m_scfg, m_mask, m_rdata;
   logic [31:0] m_pid;
   bit m_pid_ok;
   int m_evt;
   logic m_load;
   logic [2:0] m_load_val;

   task automatic m_reset();
      for (int i = 0; i < NC; i++) m_data[i] = 8'h80;
      m_tmo = 8'h10; m_pulse = 8'h04; m_vin = 8'h00; m_scfg = 8'h00;
      m_mask = 8'hFF; m_rdata = 8'h00; m_pid = '0; m_pid_ok = 1'b0;
      m_evt = 0; m_load = 1'b0; m_load_val = '0;
   endtask

   initial m_reset();

   function automatic logic [7:0] mg(input logic [7:0] old, input logic [7:0] nw);
      return (nw & m_mask) | (old & ~m_mask);
   endfunction

   function automatic logic [7:0] mread(input logic [7:0] a);
      if (a == 8'h00) return 8'h12;
      if (a == 8'h01) return 8'h02;
      if (a == 8'h02) return 8'h00;
      if (a == 8'h03) return 8'h01;
      if (a >= 8'h04 && a <= 8'h07) return m_pid[31 - 8*(int'(a) - 4) -: 8];
      if (a >= 8'h10 && a < 8'h10 + NC) return live[(int'(a) - 16)*8 +: 8];
      if (a >= 8'h20 && a < 8'h20 + NC) return m_data[int'(a) - 32];
      case (a)
         8'h30: return m_tmo;
         8'h31: return m_pulse;
         8'h32: return 8'(m_evt);
         8'h38: return {5'b0, fsm_q};
         8'hE0: return m_vin;
         8'hE1: return vout;
         8'hF0: return {7'b0, m_scfg[0]};
         8'hF8: return m_mask;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         if (re) m_rdata = mread(addr) & ((addr == 8'hF8) ? 8'hFF : m_mask);
         if (!m_pid_ok) begin m_pid = prog_id; m_pid_ok = 1'b1; end
         if (re && addr == 8'h32) m_evt = evt ? 1 : 0;
         else if (evt && m_evt < 255) m_evt = m_evt + 1;
         m_load = 1'b0;
         if (we) begin
            if (addr >= 8'h20 && addr < 8'h20 + NC)
               m_data[int'(addr) - 32] = mg(m_data[int'(addr) - 32], wdata);
            case (addr)
               8'h30: m_tmo = mg(m_tmo, wdata);
               8'h31: m_pulse = mg(m_pulse, wdata);
               8'hE0: m_vin = mg(m_vin, wdata);
               8'hF0: m_scfg = mg(m_scfg, wdata);
               8'h38: begin
                  m_load = 1'b1;
                  m_load_val = mg({5'b0, fsm_q}, wdata) >> 0;
               end
               8'hF8: m_mask = wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (cmp_en) begin
      logic [NC*8-1:0] er;
      for (int i = 0; i < NC; i++) er[i*8 +: 8] = m_data[i];
      chk("R3 model rdata", 32'(rdata), 32'(m_rdata));
      chk("R5 model reload", 32'(reload[31:0]), 32'(er[31:0]));
      chk("R5 model reload hi", 32'(reload[NC*8-1:32]), 32'(er[NC*8-1:32]));
      chk("R12 model tmo/pulse", {16'h0, tmo, pulse}, {16'h0, m_tmo, m_pulse});
      chk("R9 model vin", 32'(vin), 32'(m_vin));
      chk("R10 model autoinc", 32'(autoinc), 32'(m_scfg[0]));
      chk("R7 model load", {28'h0, load, load_val}, {28'h0, m_load, m_load ? m_load_val : load_val});
   end

   // ---------------- stimulus helpers (entered at a negedge) ----------------
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      re = 1'b1; addr = a;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, 32'(d), 32'(exp));
   endtask

   initial begin
      logic [7:0] d, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1'b1;

      // R1 reset state
      chk("R1 reload byte0", 32'(reload[7:0]), 32'h80);
      chk("R1 reload byte7", 32'(reload[63:56]), 32'h80);
      chk("R1 timeout/pulse", {16'h0, tmo, pulse}, 32'h1004);
      chk("R1 vin/autoinc/load", {vin, 7'b0, autoinc, 7'b0, load, 8'h0}, 32'h0);
      chk("R1 rdata", 32'(rdata), 32'h0);
      rd_chk("R1 mask", 8'hF8, 8'hFF);

      // R2 identification
      rd_chk("R2 code0", 8'h00, 8'h12);
      rd_chk("R2 code1", 8'h01, 8'h02);
      rd_chk("R2 byte2", 8'h02, 8'h00);
      rd_chk("R2 rev", 8'h03, 8'h01);
      rd_chk("R2 pid msb", 8'h04, 8'hA5);
      rd_chk("R2 pid b1", 8'h05, 8'hC3);
      rd_chk("R2 pid b2", 8'h06, 8'h1E);
      rd_chk("R2 pid lsb", 8'h07, 8'h77);
      wr(8'h04, 8'hFF);
      rd_chk("R2 pid after write", 8'h04, 8'hA5);

      // R3 hold when idle
      rd_chk("R3 read", 8'h00, 8'h12);
      repeat (3) @(negedge clk);
      chk("R3 hold", 32'(rdata), 32'h12);

      // R4 live snapshot
      exp = live_base + 8'd48;
      rd_chk("R4 snap3", 8'h13, exp);
      exp = live_base;
      rd_chk("R4 snap0", 8'h10, exp);
      wr(8'h13, 8'h00);
      chk("R4 write ignored", 32'(reload[31:24]), 32'h80);

      // R5 reload values
      wr(8'h26, 8'h3C);
      chk("R5 cnt6 output", 32'(reload[55:48]), 32'h3C);
      rd_chk("R5 cnt6 read", 8'h26, 8'h3C);
      wr(8'h20, 8'h01);
      chk("R5 cnt0 output", 32'(reload[7:0]), 32'h01);

      // R12 watchdog settings
      wr(8'h30, 8'h55);
      wr(8'h31, 8'h07);
      chk("R12 outputs", {16'h0, tmo, pulse}, 32'h5507);
      rd_chk("R12 tmo read", 8'h30, 8'h55);

      // R6 event counter
      evt = 1'b1; repeat (3) @(negedge clk); evt = 1'b0;
      rd_chk("R6 count", 8'h32, 8'h03);
      rd_chk("R6 cleared", 8'h32, 8'h00);
      evt = 1'b1; repeat (260) @(negedge clk); evt = 1'b0;
      rd_chk("R6 saturate", 8'h32, 8'hFF);
      evt = 1'b1; repeat (2) @(negedge clk);
      rd(8'h32, d);
      evt = 1'b0;
      chk("R6 read with event", 32'(d), 32'h02);
      rd_chk("R6 event kept", 8'h32, 8'h01);

      // R7 force state
      rd_chk("R7 read state", 8'h38, 8'h05);
      wr(8'h38, 8'h03);
      chk("R7 pulse", {28'h0, load, load_val}, 32'hB);
      @(negedge clk);
      chk("R7 single cycle", {28'h0, load, 1'b0, fsm_q}, 32'h3);
      rd_chk("R7 state forced", 8'h38, 8'h03);
      wr(8'h38, 8'hFE);
      chk("R7 low bits only", 32'(load_val), 32'h6);
      @(negedge clk);
      rd_chk("R7 upper zero", 8'h38, 8'h06);

      // R8 mask
      wr(8'hE0, 8'h50);
      wr(8'hF8, 8'h0F);
      wr(8'hE0, 8'hAB);
      chk("R8 masked write", 32'(vin), 32'h5B);
      rd_chk("R8 masked read", 8'hE0, 8'h0B);
      rd_chk("R8 mask exempt", 8'hF8, 8'h0F);
      wr(8'hF8, 8'hF0);
      wr(8'h38, 8'h07);
      chk("R8 R7 masked force", {28'h0, load, load_val}, 32'hE);
      wr(8'hF8, 8'hFF);
      rd_chk("R8 unmasked again", 8'hE0, 8'h5B);

      // R3 read and write in one cycle
      re = 1'b1; we = 1'b1; addr = 8'hE0; wdata = 8'h77;
      @(negedge clk);
      re = 1'b0; we = 1'b0;
      chk("R3 old value on same-cycle write", 32'(rdata), 32'h5B);
      chk("R9 vin updated", 32'(vin), 32'h77);

      // R9 virtual output
      rd_chk("R9 vout", 8'hE1, 8'hC6);
      wr(8'hE1, 8'h00);
      rd_chk("R9 vout write ignored", 8'hE1, 8'hC6);

      // R10 serial config
      wr(8'hF0, 8'hFF);
      chk("R10 autoinc set", 32'(autoinc), 32'h1);
      rd_chk("R10 read bit0 only", 8'hF0, 8'h01);
      wr(8'hF0, 8'h00);
      chk("R10 autoinc clear", 32'(autoinc), 32'h0);

      // R11 unmapped
      rd_chk("R11 unmapped 0x50", 8'h50, 8'h00);
      rd_chk("R11 unmapped 0xFF", 8'hFF, 8'h00);
      wr(8'h50, 8'h99);
      rd_chk("R11 write ignored", 8'h50, 8'h00);
      rd_chk("R11 gap 0x08", 8'h08, 8'h00);
      rd_chk("R11 state intact", 8'h26, 8'h3C);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule